// File: doc/BRIEF.md
# Security Configuration Register Bank

This block is the software-visible control side of a memory filter that splits a protected memory into fixed-size blocks and marks each block as secure or non-secure. It sits on a simple single-cycle 32-bit register bus with byte lanes and a secure attribute. The bank holds a control word and a table of 32-bit configuration words, one bit per block. Software reaches the table through an index register and a data window, and the index can step on by itself after each full-word window access. The bank also holds an interrupt status, enable, set and clear group, and two fault-information words. The blocked-access filter beside this bank loads those words on the first rejected access. A lockdown bit freezes the security-relevant state until the next reset.

The table contents, the control bits and the interrupt line are brought out as ports for the filter datapath. Read data returns one cycle after the read request with a valid strobe. The register bank only answers secure requests; a non-secure request gets zero data and has no effect, except in the identification range at 0xFD0 and above, which reads as zero in this bank.

Top module: `sec_cfg_regs`

## Requirements
- R1: After reset the control word is 0x00000100, the index, interrupt status and both fault words are 0, interrupt enable is 1, every table word is 0 and the interrupt output is low.
- R2: In the control word at offset 0x00, bit 4 drives the error-response select output, bit 8 enables index auto-advance and bit 31 is lockdown. All other bits read 0 and ignore writes.
- R3: A non-secure access to any offset below 0xFD0 returns zero on a read and changes no state on a write.
- R4: With auto-advance on, a secure full-word (all four byte enables) read or write of the window at 0x1C moves the index at 0x18 to (index+1) modulo the number of table words. A narrow window access, or any access with auto-advance off, leaves the index unchanged.
- R5: A write to the index register stores the value modulo the number of table words. Offset 0x10 reads the number of table words minus 1. Offset 0x14 reads log2(block size in bytes) minus 5.
- R6: Once lockdown is set, writes to control, to the window (including its index advance) and to interrupt enable at 0x28 are ignored, and lockdown stays set until reset.
- R7: A byte or halfword write to control, index or the window replaces only the enabled bytes of the current value. A narrow write to interrupt enable fills the unwritten bytes with zero.
- R8: Writing a 1 in bit 0 of the set register at 0x34 raises the status bit at 0x20. Writing a 1 in bit 0 of the clear register at 0x24 drops it. The interrupt output is status AND enable.
- R9: A fault event while status is 0 captures the faulting address into the word at 0x2C and fills the word at 0x30 with the master ID in bits 15:0, the non-secure flag in bit 16 and the block's table bit in bit 17, and sets status. Fault events while status is 1 change neither word.
- R10: Reads of the set, clear, identification and undefined offsets return zero. Writes to read-only or undefined offsets change nothing.
- R11: Read data carries only the bytes whose enables are set; the other byte lanes are zero.
- R12: Table word k appears on the table output at bits 32k+31 down to 32k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address in the register space |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte lane enables |
| secure_i | input | 1 | Access is secure |
| rdata_o | output | 32 | Read data, one cycle after the request |
| rvalid_o | output | 1 | Read data valid |
| flt_valid_i | input | 1 | Filter reports a blocked access |
| flt_addr_i | input | 32 | Address of the blocked access |
| flt_master_i | input | 16 | Master ID of the blocked access |
| flt_nonsec_i | input | 1 | Blocked access was non-secure |
| flt_cfg_ns_i | input | 1 | Table bit of the targeted block |
| lut_o | output | 32*LUT_WORDS | Flattened table contents |
| sec_resp_o | output | 1 | Error-response select for blocked accesses |
| autoinc_o | output | 1 | Index auto-advance enable |
| lockdown_o | output | 1 | Lockdown state |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the index wrap combined with the byte-lane rules. The index must sit on the last table word when a full-word window access arrives, and a narrow window access must be seen not to move it. The stimulus reaches this by writing an out-of-range index so the modulo lands it on word 2, then making two full-word writes that step it through word 3 back to 0. After that, narrow and full window accesses are mixed and the index is read back after each one. Lockdown is entered last, because it cannot be left without a reset. There, a locked window write that must neither change the table nor advance the index is placed next to a window read that still advances it.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;

  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_MAXIDX = 12'h010;
  localparam logic [11:0] OFS_BLKCFG = 12'h014;
  localparam logic [11:0] OFS_IDX    = 12'h018;
  localparam logic [11:0] OFS_WIN    = 12'h01C;
  localparam logic [11:0] OFS_STAT   = 12'h020;
  localparam logic [11:0] OFS_CLR    = 12'h024;
  localparam logic [11:0] OFS_EN     = 12'h028;
  localparam logic [11:0] OFS_INFO1  = 12'h02C;
  localparam logic [11:0] OFS_INFO2  = 12'h030;
  localparam logic [11:0] OFS_SET    = 12'h034;
  localparam logic [11:0] OFS_IDBASE = 12'hFD0;

  localparam int CTRL_RESP_BIT = 4;
  localparam int CTRL_AINC_BIT = 8;
  localparam int CTRL_LOCK_BIT = 31;
  localparam logic [31:0] CTRL_MASK = 32'h8000_0110;
  localparam logic [31:0] CTRL_RST  = 32'h0000_0100;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_MAXIDX,
    SEL_BLKCFG,
    SEL_IDX,
    SEL_WIN,
    SEL_STAT,
    SEL_CLR,
    SEL_EN,
    SEL_INFO1,
    SEL_INFO2,
    SEL_SET
  } reg_sel_e;

  // replace enabled byte lanes of cur with nxt
  function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                             input logic [31:0] nxt,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[b*8 +: 8] = be[b] ? nxt[b*8 +: 8] : cur[b*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[b*8 +: 8] = {8{be[b]}};
    end
    return r;
  endfunction

endpackage

// File: rtl/sec_cfg_dec.sv
module sec_cfg_dec
  import sec_cfg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic              secure_i,
  output reg_sel_e          sel_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              full_o
);

  logic [ADDR_W-1:0] word_addr;
  logic              allowed;

  assign word_addr = addr_i & ~ADDR_W'(3);
  // non-secure requests only reach the identification range
  assign allowed   = secure_i || (word_addr >= ADDR_W'(OFS_IDBASE));
  assign rd_o      = req_i && !we_i;
  assign wr_o      = req_i && we_i && allowed;
  assign full_o    = &be_i;

  always_comb begin
    sel_o = SEL_NONE;
    if (allowed) begin
      case (word_addr)
        ADDR_W'(OFS_CTRL):   sel_o = SEL_CTRL;
        ADDR_W'(OFS_MAXIDX): sel_o = SEL_MAXIDX;
        ADDR_W'(OFS_BLKCFG): sel_o = SEL_BLKCFG;
        ADDR_W'(OFS_IDX):    sel_o = SEL_IDX;
        ADDR_W'(OFS_WIN):    sel_o = SEL_WIN;
        ADDR_W'(OFS_STAT):   sel_o = SEL_STAT;
        ADDR_W'(OFS_CLR):    sel_o = SEL_CLR;
        ADDR_W'(OFS_EN):     sel_o = SEL_EN;
        ADDR_W'(OFS_INFO1):  sel_o = SEL_INFO1;
        ADDR_W'(OFS_INFO2):  sel_o = SEL_INFO2;
        ADDR_W'(OFS_SET):    sel_o = SEL_SET;
        default:             sel_o = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sec_cfg_lut.sv
module sec_cfg_lut
  import sec_cfg_pkg::*;
#(
  parameter int LUT_WORDS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    win_wr_i,
  input  logic                    win_rd_i,
  input  logic                    idx_wr_i,
  input  logic                    full_i,
  input  logic                    autoinc_i,
  input  logic                    locked_i,
  input  logic [31:0]             wdata_i,
  input  logic [3:0]              be_i,
  output logic [IDX_W-1:0]        idx_o,
  output logic [31:0]             cur_word_o,
  output logic [LUT_WORDS*32-1:0] lut_o
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_inc;
  logic [IDX_W-1:0] idx_wr_val;
  logic [31:0]      idx_merged;
  logic [31:0]      word_q [LUT_WORDS];
  logic             win_wr_ok;
  logic             advance;

  assign win_wr_ok  = win_wr_i && !locked_i;
  assign advance    = full_i && autoinc_i && (win_wr_ok || win_rd_i);
  assign idx_inc    = (32'(idx_q) == LUT_WORDS - 1) ? '0 : idx_q + IDX_W'(1);
  assign idx_merged = lane_merge(32'(idx_q), wdata_i, be_i);
  assign idx_wr_val = IDX_W'(idx_merged % 32'(LUT_WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (idx_wr_i) begin
      idx_q <= idx_wr_val;
    end else if (advance) begin
      idx_q <= idx_inc;
    end
  end

  for (genvar k = 0; k < LUT_WORDS; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[k] <= '0;
      end else if (win_wr_ok && (32'(idx_q) == k)) begin
        word_q[k] <= lane_merge(word_q[k], wdata_i, be_i);
      end
    end
    assign lut_o[k*32 +: 32] = word_q[k];
  end

  assign cur_word_o = word_q[idx_q];
  assign idx_o      = idx_q;

endmodule

// File: rtl/sec_cfg_irq.sv
module sec_cfg_irq #(
  parameter int MASTER_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic                clr_i,
  input  logic                en_wr_i,
  input  logic                en_val_i,
  input  logic                flt_valid_i,
  input  logic [31:0]         flt_addr_i,
  input  logic [MASTER_W-1:0] flt_master_i,
  input  logic                flt_nonsec_i,
  input  logic                flt_cfg_ns_i,
  output logic                stat_o,
  output logic                en_o,
  output logic [31:0]         info1_o,
  output logic [31:0]         info2_o,
  output logic                irq_o
);

  logic        stat_q;
  logic        en_q;
  logic [31:0] info1_q;
  logic [31:0] info2_q;
  logic        capture;

  // only the first fault after a clear is recorded
  assign capture = flt_valid_i && !stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= 1'b0;
      en_q    <= 1'b1;
      info1_q <= '0;
      info2_q <= '0;
    end else begin
      if (capture) begin
        info1_q <= flt_addr_i;
        info2_q <= {14'd0, flt_cfg_ns_i, flt_nonsec_i, 16'(flt_master_i)};
      end
      if (capture || set_i) begin
        stat_q <= 1'b1;
      end else if (clr_i) begin
        stat_q <= 1'b0;
      end
      if (en_wr_i) begin
        en_q <= en_val_i;
      end
    end
  end

  assign stat_o  = stat_q;
  assign en_o    = en_q;
  assign info1_o = info1_q;
  assign info2_o = info2_q;
  assign irq_o   = stat_q && en_q;

endmodule

// File: rtl/sec_cfg_regs.sv
module sec_cfg_regs
  import sec_cfg_pkg::*;
#(
  parameter int BLK_BYTES = 4096,
  parameter int LUT_WORDS = 4,
  parameter int ADDR_W    = 12,
  parameter int MASTER_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [31:0]             wdata_i,
  input  logic [3:0]              be_i,
  input  logic                    secure_i,
  output logic [31:0]             rdata_o,
  output logic                    rvalid_o,
  input  logic                    flt_valid_i,
  input  logic [31:0]             flt_addr_i,
  input  logic [MASTER_W-1:0]     flt_master_i,
  input  logic                    flt_nonsec_i,
  input  logic                    flt_cfg_ns_i,
  output logic [LUT_WORDS*32-1:0] lut_o,
  output logic                    sec_resp_o,
  output logic                    autoinc_o,
  output logic                    lockdown_o,
  output logic                    irq_o
);

  localparam int IDX_W      = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1;
  localparam int BLKCFG_VAL = $clog2(BLK_BYTES) - 5;

  reg_sel_e         sel;
  logic             acc_rd;
  logic             acc_wr;
  logic             acc_full;
  logic [31:0]      ctrl_q;
  logic [IDX_W-1:0] blk_idx;
  logic [31:0]      cur_word;
  logic             stat;
  logic             int_en;
  logic [31:0]      info1;
  logic [31:0]      info2;
  logic             set_hit;
  logic             clr_hit;
  logic             en_wr;
  logic [31:0]      rd_mux;

  sec_cfg_dec #(.ADDR_W(ADDR_W)) dec_i (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .be_i     (be_i),
    .secure_i (secure_i),
    .sel_o    (sel),
    .rd_o     (acc_rd),
    .wr_o     (acc_wr),
    .full_o   (acc_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (acc_wr && sel == SEL_CTRL && !lockdown_o) begin
      ctrl_q <= lane_merge(ctrl_q, wdata_i, be_i) & CTRL_MASK;
    end
  end

  assign sec_resp_o = ctrl_q[CTRL_RESP_BIT];
  assign autoinc_o  = ctrl_q[CTRL_AINC_BIT];
  assign lockdown_o = ctrl_q[CTRL_LOCK_BIT];

  sec_cfg_lut #(.LUT_WORDS(LUT_WORDS), .IDX_W(IDX_W)) lut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_wr_i   (acc_wr && sel == SEL_WIN),
    .win_rd_i   (acc_rd && sel == SEL_WIN),
    .idx_wr_i   (acc_wr && sel == SEL_IDX),
    .full_i     (acc_full),
    .autoinc_i  (autoinc_o),
    .locked_i   (lockdown_o),
    .wdata_i    (wdata_i),
    .be_i       (be_i),
    .idx_o      (blk_idx),
    .cur_word_o (cur_word),
    .lut_o      (lut_o)
  );

  assign set_hit = acc_wr && sel == SEL_SET && be_i[0] && wdata_i[0];
  assign clr_hit = acc_wr && sel == SEL_CLR && be_i[0] && wdata_i[0];
  assign en_wr   = acc_wr && sel == SEL_EN && !lockdown_o;

  sec_cfg_irq #(.MASTER_W(MASTER_W)) irq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_hit),
    .clr_i        (clr_hit),
    .en_wr_i      (en_wr),
    .en_val_i     (be_i[0] && wdata_i[0]),
    .flt_valid_i  (flt_valid_i),
    .flt_addr_i   (flt_addr_i),
    .flt_master_i (flt_master_i),
    .flt_nonsec_i (flt_nonsec_i),
    .flt_cfg_ns_i (flt_cfg_ns_i),
    .stat_o       (stat),
    .en_o         (int_en),
    .info1_o      (info1),
    .info2_o      (info2),
    .irq_o        (irq_o)
  );

  always_comb begin
    case (sel)
      SEL_CTRL:   rd_mux = ctrl_q;
      SEL_MAXIDX: rd_mux = 32'(LUT_WORDS - 1);
      SEL_BLKCFG: rd_mux = 32'(BLKCFG_VAL);
      SEL_IDX:    rd_mux = 32'(blk_idx);
      SEL_WIN:    rd_mux = cur_word;
      SEL_STAT:   rd_mux = {31'd0, stat};
      SEL_EN:     rd_mux = {31'd0, int_en};
      SEL_INFO1:  rd_mux = info1;
      SEL_INFO2:  rd_mux = info2;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= acc_rd;
      if (acc_rd) begin
        rdata_o <= rd_mux & lane_mask(be_i);
      end
    end
  end

endmodule

// File: rtl/sec_cfg_chk.sv
module sec_cfg_chk
  import sec_cfg_pkg::*;
#(
  parameter int LUT_WORDS = 4,
  parameter int IDX_W     = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    we_i,
  input logic                    secure_i,
  input logic                    flt_valid_i,
  input reg_sel_e                sel,
  input logic                    acc_wr,
  input logic                    acc_full,
  input logic                    clr_hit,
  input logic [IDX_W-1:0]        blk_idx,
  input logic [LUT_WORDS*32-1:0] lut_o,
  input logic                    sec_resp_o,
  input logic                    autoinc_o,
  input logic                    lockdown_o,
  input logic                    irq_o
);

  // R6
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockdown_o |=> lockdown_o);

  // R6
  lock_table_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockdown_o |=> $stable(lut_o));

  // R3
  ns_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !secure_i) |=>
      ($stable(lut_o) && $stable({lockdown_o, autoinc_o, sec_resp_o})));

  // R8
  clr_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && !flt_valid_i) |=> !irq_o);

  // R5
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(blk_idx) < LUT_WORDS);

  // R4
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && sel == SEL_WIN && acc_full && autoinc_o && !lockdown_o) |=>
      (32'(blk_idx) == (32'($past(blk_idx)) + 1) % LUT_WORDS));

endmodule

bind sec_cfg_regs sec_cfg_chk #(.LUT_WORDS(LUT_WORDS), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/sec_cfg_regs_tb_top.sv
module sec_cfg_regs_tb_top;

  localparam int LUT_WORDS = 4;

  logic                    clk = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    req_i = 1'b0;
  logic                    we_i = 1'b0;
  logic [11:0]             addr_i = '0;
  logic [31:0]             wdata_i = '0;
  logic [3:0]              be_i = '0;
  logic                    secure_i = 1'b0;
  logic [31:0]             rdata_o;
  logic                    rvalid_o;
  logic                    flt_valid_i = 1'b0;
  logic [31:0]             flt_addr_i = '0;
  logic [15:0]             flt_master_i = '0;
  logic                    flt_nonsec_i = 1'b0;
  logic                    flt_cfg_ns_i = 1'b0;
  logic [LUT_WORDS*32-1:0] lut_o;
  logic                    sec_resp_o;
  logic                    autoinc_o;
  logic                    lockdown_o;
  logic                    irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  sec_cfg_regs #(.BLK_BYTES(4096), .LUT_WORDS(LUT_WORDS)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .be_i         (be_i),
    .secure_i     (secure_i),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o),
    .flt_valid_i  (flt_valid_i),
    .flt_addr_i   (flt_addr_i),
    .flt_master_i (flt_master_i),
    .flt_nonsec_i (flt_nonsec_i),
    .flt_cfg_ns_i (flt_cfg_ns_i),
    .lut_o        (lut_o),
    .sec_resp_o   (sec_resp_o),
    .autoinc_o    (autoinc_o),
    .lockdown_o   (lockdown_o),
    .irq_o        (irq_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] b, input logic s);
    @(negedge clk);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d; be_i = b; secure_i = s;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus(1'b1, a, d, 4'hF, 1'b1);
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [3:0] b,
                    input logic s, input logic [31:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus(1'b0, a, 32'd0, b, s);
  endtask

  task automatic fault(input logic [31:0] a, input logic [15:0] m,
                       input logic ns, input logic cfg);
    @(negedge clk);
    flt_valid_i = 1'b1; flt_addr_i = a; flt_master_i = m;
    flt_nonsec_i = ns; flt_cfg_ns_i = cfg;
    @(negedge clk);
    flt_valid_i = 1'b0;
  endtask

  // monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        chk("unexpected read", 128'(rdata_o), 128'(0));
      end else begin
        chk(tag_q.pop_front(), 128'(rdata_o), 128'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 lut", 128'(lut_o), 128'(0));
    chk("R1 irq", 128'(irq_o), 128'(0));
    chk("R1 ctrl outputs", 128'({lockdown_o, autoinc_o, sec_resp_o}), 128'(3'b010));
    rd("R1 ctrl", 12'h000, 4'hF, 1'b1, 32'h0000_0100);
    rd("R1 idx", 12'h018, 4'hF, 1'b1, 32'd0);
    rd("R1 stat", 12'h020, 4'hF, 1'b1, 32'd0);
    rd("R1 en", 12'h028, 4'hF, 1'b1, 32'd1);
    rd("R1 info1", 12'h02C, 4'hF, 1'b1, 32'd0);
    rd("R1 info2", 12'h030, 4'hF, 1'b1, 32'd0);
    rd("R5 maxidx", 12'h010, 4'hF, 1'b1, 32'd3);
    rd("R5 blkcfg", 12'h014, 4'hF, 1'b1, 32'd7);

    // R2 control field mask
    wr(12'h000, 32'h7FFF_FFFF);
    rd("R2 ctrl mask", 12'h000, 4'hF, 1'b1, 32'h0000_0110);
    chk("R2 sec_resp", 128'(sec_resp_o), 128'(1));

    // R5 index modulo
    wr(12'h018, 32'd6);
    rd("R5 idx mod", 12'h018, 4'hF, 1'b1, 32'd2);

    // R4 advance and wrap, R12 table layout
    wr(12'h01C, 32'hA0A0_0002);
    wr(12'h01C, 32'h0000_00A3);
    rd("R4 wrap", 12'h018, 4'hF, 1'b1, 32'd0);
    chk("R12 lut", 128'(lut_o), {32'h0000_00A3, 32'hA0A0_0002, 64'd0});

    // R4 narrow window write does not advance
    bus(1'b1, 12'h01C, 32'h0000_5500, 4'b0010, 1'b1);
    rd("R4 narrow hold", 12'h018, 4'hF, 1'b1, 32'd0);
    chk("R7 narrow win fill", 128'(lut_o[31:0]), 128'(32'h0000_5500));
    wr(12'h01C, 32'h1122_3344);
    rd("R4 full step", 12'h018, 4'hF, 1'b1, 32'd1);

    // R7 narrow merge, R11 narrow read, R4 read advance
    wr(12'h018, 32'd2);
    bus(1'b1, 12'h01C, 32'h00EE_0000, 4'b0100, 1'b1);
    chk("R7 win merge", 128'(lut_o[95:64]), 128'(32'hA0EE_0002));
    rd("R11 narrow read", 12'h01C, 4'b0001, 1'b1, 32'h0000_0002);
    rd("R4 narrow read hold", 12'h018, 4'hF, 1'b1, 32'd2);
    rd("R4 win full read", 12'h01C, 4'hF, 1'b1, 32'hA0EE_0002);
    rd("R4 read step", 12'h018, 4'hF, 1'b1, 32'd3);

    // R4 auto-advance off
    wr(12'h000, 32'h0000_0010);
    wr(12'h01C, 32'h0000_0033);
    rd("R4 no advance", 12'h018, 4'hF, 1'b1, 32'd3);
    chk("R12 word3", 128'(lut_o[127:96]), 128'(32'h0000_0033));

    // R7 narrow merges on ctrl and idx, zero fill on enable
    bus(1'b1, 12'h000, 32'h0000_0100, 4'b0010, 1'b1);
    rd("R7 ctrl merge", 12'h000, 4'hF, 1'b1, 32'h0000_0110);
    bus(1'b1, 12'h018, 32'h0000_0001, 4'b0001, 1'b1);
    rd("R7 idx merge", 12'h018, 4'hF, 1'b1, 32'd1);
    bus(1'b1, 12'h028, 32'h0000_0100, 4'b0010, 1'b1);
    rd("R7 en zero fill", 12'h028, 4'hF, 1'b1, 32'd0);
    wr(12'h028, 32'd1);

    // R3 non-secure accesses
    bus(1'b1, 12'h000, 32'd0, 4'hF, 1'b0);
    rd("R3 ctrl kept", 12'h000, 4'hF, 1'b1, 32'h0000_0110);
    rd("R3 ns read", 12'h000, 4'hF, 1'b0, 32'd0);
    bus(1'b1, 12'h01C, 32'h0000_DEAD, 4'hF, 1'b0);
    chk("R3 lut kept", 128'(lut_o), {32'h33, 32'hA0EE_0002, 32'd0, 32'h1122_3344});
    bus(1'b1, 12'h034, 32'd1, 4'hF, 1'b0);
    chk("R3 ns set", 128'(irq_o), 128'(0));
    rd("R10 ns id read", 12'hFE0, 4'hF, 1'b0, 32'd0);

    // R8 set, enable gating, clear
    wr(12'h034, 32'd1);
    chk("R8 set irq", 128'(irq_o), 128'(1));
    rd("R8 stat", 12'h020, 4'hF, 1'b1, 32'd1);
    wr(12'h028, 32'd0);
    chk("R8 en gate", 128'(irq_o), 128'(0));
    wr(12'h028, 32'd1);
    chk("R8 en ungate", 128'(irq_o), 128'(1));
    wr(12'h024, 32'd1);
    chk("R8 clear", 128'(irq_o), 128'(0));
    rd("R8 stat clr", 12'h020, 4'hF, 1'b1, 32'd0);

    // R9 fault capture, first one only
    fault(32'h1234_5000, 16'h00AB, 1'b1, 1'b0);
    chk("R9 irq", 128'(irq_o), 128'(1));
    fault(32'h0000_0040, 16'h0001, 1'b0, 1'b1);
    rd("R9 info1", 12'h02C, 4'hF, 1'b1, 32'h1234_5000);
    rd("R9 info2", 12'h030, 4'hF, 1'b1, 32'h0001_00AB);
    wr(12'h024, 32'd1);
    fault(32'h8000_0004, 16'hFFFF, 1'b0, 1'b1);
    rd("R9 info1 recap", 12'h02C, 4'hF, 1'b1, 32'h8000_0004);
    rd("R9 info2 recap", 12'h030, 4'hF, 1'b1, 32'h0002_FFFF);
    rd("R11 info2 half", 12'h030, 4'b1100, 1'b1, 32'h0002_0000);
    wr(12'h024, 32'd1);

    // R10 write-only, id and undefined offsets
    rd("R10 clr read", 12'h024, 4'hF, 1'b1, 32'd0);
    rd("R10 set read", 12'h034, 4'hF, 1'b1, 32'd0);
    rd("R10 id read", 12'hFD0, 4'hF, 1'b1, 32'd0);
    rd("R10 undef read", 12'h040, 4'hF, 1'b1, 32'd0);
    wr(12'h02C, 32'hFFFF_FFFF);
    rd("R10 info1 ro", 12'h02C, 4'hF, 1'b1, 32'h8000_0004);
    wr(12'h010, 32'd0);
    rd("R10 maxidx ro", 12'h010, 4'hF, 1'b1, 32'd3);

    // R6 lockdown
    wr(12'h000, 32'h8000_0100);
    chk("R6 lock on", 128'(lockdown_o), 128'(1));
    wr(12'h000, 32'd0);
    rd("R6 ctrl frozen", 12'h000, 4'hF, 1'b1, 32'h8000_0100);
    wr(12'h018, 32'd0);
    wr(12'h01C, 32'h0000_0055);
    chk("R6 lut frozen", 128'(lut_o), {32'h33, 32'hA0EE_0002, 32'd0, 32'h1122_3344});
    rd("R6 no wr advance", 12'h018, 4'hF, 1'b1, 32'd0);
    rd("R4 locked read", 12'h01C, 4'hF, 1'b1, 32'h1122_3344);
    rd("R4 locked read step", 12'h018, 4'hF, 1'b1, 32'd1);
    wr(12'h028, 32'd0);
    rd("R6 en frozen", 12'h028, 4'hF, 1'b1, 32'd1);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 128'(exp_q.size()), 128'(0));
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule